// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block sits behind a network receive path and moves finished frames into memory. It walks a ring of 16-byte receive descriptors that software sets up in memory. For each descriptor it reads the ownership word and the buffer pointer. It then packs the incoming byte stream into 32-bit little-endian words and writes them into that buffer. When the last byte has arrived, it writes the first descriptor word back. That word carries a ready flag, the stored byte count and the frame's status bits. Software returns a descriptor by clearing its ready flag. A descriptor whose ready flag is still set is treated as not available. In that case the frame that arrives is discarded and two interrupt pulses report the missing buffer and the lost packet.

Configuration is static while the engine runs: a ring base address, a maximum stored length per buffer and an enable bit. The memory port is a single 32-bit port with byte enables. A read strobe returns data in the following cycle, and a write completes in the cycle it is issued. The stream input has a ready output, because the engine must finish fetching a descriptor before it can accept the first byte of a frame.

Top module: `rx_desc_writeback`

## Requirements
- R1: After `cfgEnable` rises, the engine reads descriptor word 0 at `cfgRingBase` and then word 3 at `cfgRingBase+12`. Bit 31 of word 0 is the ready flag. Word 3 is the word-aligned buffer address.
- R2: If that ready flag is clear, the stored bytes of a frame appear at consecutive byte addresses starting at the buffer address, with byte n of each 32-bit word in bits 8n+7:8n. Every memory write has at least one byte enable set.
- R3: The cycle after the last byte, word 0 is written back as follows. Bit 31 is set. Bits 29 and 28 (first and last segment) are both set. Bits 13:0 hold the stored byte count. Bit 30 (end of ring) keeps the value that was fetched.
- R4: Status bits of word 0 are taken from `inStat`, sampled on the last beat. `inStat[0]` goes to bit 16 (multicast), `[1]` to bit 17 (broadcast), `[2]` to bit 18 (receive error), `[3]` to bit 19 (CRC error) and `[4]` to bit 22 (odd nibble). All other bits from 27 down to 14 are zero, except bits 20 and 21.
- R5: Bit 21 (runt) is set exactly when the frame was not truncated and its byte count is below 64.
- R6: A frame longer than `cfgBufSize` bytes stores only its first `cfgBufSize` bytes. The count field then equals `cfgBufSize`, bit 20 (too long) is set, and no byte at or beyond the limit is written.
- R7: After a writeback the engine moves 16 bytes down the ring. After a descriptor whose bit 30 was set, it returns to `cfgRingBase`.
- R8: If the fetched ready flag is set, the next frame is accepted and discarded, and nothing is written to memory. `irqNoBuf` and `irqLost` each pulse high for exactly one cycle, the cycle after the last beat. The same descriptor is polled again until software clears its ready flag.
- R9: While `cfgEnable` is low and no frame is in progress, `inReady` is low and the memory port is idle. Enabling again restarts at `cfgRingBase`.
- R10: After the last beat of any frame is accepted, `inReady` is low in the next cycle.
- R11: The engine never asserts a memory read and a memory write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgEnable | input | 1 | Engine enable |
| cfgRingBase | input | 32 | Byte address of the first descriptor |
| cfgBufSize | input | 14 | Maximum stored bytes per frame |
| inValid | input | 1 | Stream byte valid |
| inReady | output | 1 | Stream byte accepted when high with inValid |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Marks the final byte of a frame |
| inStat | input | 5 | Frame status side band, sampled with inLast |
| memWrEn | output | 1 | Memory write strobe |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | 32 | Memory byte address, word aligned |
| memWrData | output | 32 | Memory write data |
| memByteEn | output | 4 | Write byte enables |
| memRdData | input | 32 | Read data, valid the cycle after memRdEn |
| irqNoBuf | output | 1 | One-cycle pulse: descriptor unavailable |
| irqLost | output | 1 | One-cycle pulse: frame discarded |

## Verification
The hardest case is a frame that arrives while the current descriptor is still owned by software. The bench only reaches it after filling the whole ring without returning any descriptor. It therefore sends four frames with no release, confirms that a fifth frame produces the interrupt pulses with no memory write, and then returns just that descriptor to check that polling picks it up. Truncation at a limit that is not a multiple of four is driven directly. Limits of 21 bytes with frames of 21, 22 and 30 bytes exercise the partial last word and the runt versus too-long boundary.

// File: rtl/rx_wb_pkg.sv
package rx_wb_pkg;

  localparam int WordW = 32;
  localparam int LaneN = WordW / 8;
  localparam int DescBytes = 16;

  // descriptor word 0 bit positions
  localparam int RdyPos = 31;
  localparam int EorPos = 30;
  localparam int FirstPos = 29;
  localparam int LastPos = 28;
  localparam int OddPos = 22;
  localparam int RuntPos = 21;
  localparam int LongPos = 20;
  localparam int CrcPos = 19;
  localparam int ErrPos = 18;
  localparam int BcastPos = 17;
  localparam int McastPos = 16;

  // side-band status index
  localparam int StMcast = 0;
  localparam int StBcast = 1;
  localparam int StErr = 2;
  localparam int StCrc = 3;
  localparam int StOdd = 4;
  localparam int StatW = 5;

  typedef enum logic [2:0] {
    sOff, sFetch0, sFetch3, sWait3, sArmed, sRecv, sWrBack, sNoBuf
  } engState_t;

  typedef struct packed {
    logic loadBase;
    logic rdWord0;
    logic rdWord3;
    logic capWord0;
    logic capWord3;
    logic startFrame;
    logic takeByte;
    logic writeBack;
    logic advance;
  } engStrobe_t;

endpackage

// File: rtl/rx_wb_ctrl.sv
module rx_wb_ctrl
  import rx_wb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEnable,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       descOwned,
  output logic       inReady,
  output engStrobe_t stb,
  output logic       irqNoBuf,
  output logic       irqLost
);

  engState_t state, nextState;
  logic dropBusy;
  logic dropEnd;

  always_comb begin
    nextState = state;
    stb = '0;
    inReady = 1'b0;
    dropEnd = 1'b0;
    unique case (state)
      sOff: begin
        stb.loadBase = 1'b1;
        if (cfgEnable) nextState = sFetch0;
      end
      sFetch0: begin
        stb.rdWord0 = 1'b1;
        nextState = sFetch3;
      end
      sFetch3: begin
        stb.capWord0 = 1'b1;
        stb.rdWord3 = 1'b1;
        nextState = sWait3;
      end
      sWait3: begin
        stb.capWord3 = 1'b1;
        nextState = descOwned ? sNoBuf : sArmed;
      end
      sArmed: begin
        inReady = cfgEnable;
        if (!cfgEnable) nextState = sOff;
        else if (inValid) begin
          stb.startFrame = 1'b1;
          stb.takeByte = 1'b1;
          nextState = inLast ? sWrBack : sRecv;
        end
      end
      sRecv: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.takeByte = 1'b1;
          if (inLast) nextState = sWrBack;
        end
      end
      sWrBack: begin
        stb.writeBack = 1'b1;
        stb.advance = 1'b1;
        nextState = cfgEnable ? sFetch0 : sOff;
      end
      sNoBuf: begin
        inReady = 1'b1;
        if (inValid) begin
          if (inLast) begin
            dropEnd = 1'b1;
            nextState = cfgEnable ? sFetch0 : sOff;
          end
        end else if (!dropBusy) begin
          nextState = cfgEnable ? sFetch0 : sOff;
        end
      end
      default: nextState = sOff;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= sOff;
      dropBusy <= 1'b0;
      irqNoBuf <= 1'b0;
      irqLost <= 1'b0;
    end else begin
      state <= nextState;
      irqNoBuf <= dropEnd;
      irqLost <= dropEnd;
      if (state == sNoBuf && inValid) dropBusy <= !inLast;
    end
  end

endmodule

// File: rtl/rx_wb_datapath.sv
module rx_wb_datapath
  import rx_wb_pkg::*;
#(
  parameter int AddrW = 32,
  parameter int CntW = 14,
  parameter int RuntLen = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  engStrobe_t       stb,
  input  logic [AddrW-1:0] cfgRingBase,
  input  logic [CntW-1:0]  cfgBufSize,
  input  logic [7:0]       inData,
  input  logic             inLast,
  input  logic [StatW-1:0] inStat,
  input  logic [WordW-1:0] memRdData,
  output logic             descOwned,
  output logic             memWrEn,
  output logic             memRdEn,
  output logic [AddrW-1:0] memAddr,
  output logic [WordW-1:0] memWrData,
  output logic [LaneN-1:0] memByteEn
);

  localparam int AccW = WordW - 8;
  localparam int PadW = AddrW - CntW;

  logic [AddrW-1:0] descAddr;
  logic [AddrW-1:0] bufBase;
  logic             eorFlag;
  logic [CntW-1:0]  byteCnt;
  logic             truncFlag;
  logic [AccW-1:0]  wordAcc;
  logic [StatW-1:0] statHold;

  logic [CntW-1:0]  curCnt;
  logic             curTrunc;
  logic             room;
  logic             storeByte;
  logic [1:0]       lane;
  logic             flush;
  logic [WordW-1:0] packWord;
  logic [LaneN-1:0] laneMask;
  logic [AddrW-1:0] dataAddr;
  logic [WordW-1:0] wbWord;
  logic             runt;

  assign curCnt = stb.startFrame ? '0 : byteCnt;
  assign curTrunc = stb.startFrame ? 1'b0 : truncFlag;
  assign room = curCnt < cfgBufSize;
  assign storeByte = stb.takeByte && room;
  assign lane = curCnt[1:0];
  assign flush = storeByte && (lane == 2'd3 || inLast || (curCnt + 1'b1) == cfgBufSize);
  assign dataAddr = bufBase + {{PadW{1'b0}}, curCnt[CntW-1:2], 2'b00};

  always_comb begin
    packWord = {8'h00, wordAcc};
    packWord[{lane, 3'b000} +: 8] = inData;
    unique case (lane)
      2'd0: laneMask = 4'b0001;
      2'd1: laneMask = 4'b0011;
      2'd2: laneMask = 4'b0111;
      default: laneMask = 4'b1111;
    endcase
  end

  assign runt = !truncFlag && (byteCnt < CntW'(RuntLen));

  always_comb begin
    wbWord = '0;
    wbWord[RdyPos] = 1'b1;
    wbWord[EorPos] = eorFlag;
    wbWord[FirstPos] = 1'b1;
    wbWord[LastPos] = 1'b1;
    wbWord[OddPos] = statHold[StOdd];
    wbWord[RuntPos] = runt;
    wbWord[LongPos] = truncFlag;
    wbWord[CrcPos] = statHold[StCrc];
    wbWord[ErrPos] = statHold[StErr];
    wbWord[BcastPos] = statHold[StBcast];
    wbWord[McastPos] = statHold[StMcast];
    wbWord[CntW-1:0] = byteCnt;
  end

  always_comb begin
    memWrEn = 1'b0;
    memRdEn = 1'b0;
    memAddr = descAddr;
    memWrData = wbWord;
    memByteEn = '1;
    if (stb.writeBack) begin
      memWrEn = 1'b1;
    end else if (flush) begin
      memWrEn = 1'b1;
      memAddr = dataAddr;
      memWrData = packWord;
      memByteEn = laneMask;
    end else if (stb.rdWord0) begin
      memRdEn = 1'b1;
    end else if (stb.rdWord3) begin
      memRdEn = 1'b1;
      memAddr = descAddr + AddrW'(12);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddr <= '0;
      bufBase <= '0;
      eorFlag <= 1'b0;
      descOwned <= 1'b0;
      byteCnt <= '0;
      truncFlag <= 1'b0;
      wordAcc <= '0;
      statHold <= '0;
    end else begin
      if (stb.loadBase) descAddr <= cfgRingBase;
      else if (stb.advance) descAddr <= eorFlag ? cfgRingBase : descAddr + AddrW'(DescBytes);
      if (stb.capWord0) begin
        descOwned <= memRdData[RdyPos];
        eorFlag <= memRdData[EorPos];
      end
      if (stb.capWord3) bufBase <= memRdData;
      if (stb.takeByte) begin
        byteCnt <= curCnt + CntW'(storeByte);
        truncFlag <= curTrunc | !room;
        if (storeByte && lane != 2'd3) wordAcc[{lane, 3'b000} +: 8] <= inData;
        if (inLast) statHold <= inStat;
      end
    end
  end

endmodule

// File: rtl/rx_desc_writeback.sv
module rx_desc_writeback
  import rx_wb_pkg::*;
#(
  parameter int AddrW = 32,
  parameter int CntW = 14,
  parameter int RuntLen = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic [AddrW-1:0] cfgRingBase,
  input  logic [CntW-1:0]  cfgBufSize,
  input  logic             inValid,
  output logic             inReady,
  input  logic [7:0]       inData,
  input  logic             inLast,
  input  logic [4:0]       inStat,
  output logic             memWrEn,
  output logic             memRdEn,
  output logic [AddrW-1:0] memAddr,
  output logic [31:0]      memWrData,
  output logic [3:0]       memByteEn,
  input  logic [31:0]      memRdData,
  output logic             irqNoBuf,
  output logic             irqLost
);

  engStrobe_t stb;
  logic descOwned;

  rx_wb_ctrl ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable),
    .inValid(inValid), .inLast(inLast), .descOwned(descOwned),
    .inReady(inReady), .stb(stb), .irqNoBuf(irqNoBuf), .irqLost(irqLost)
  );

  rx_wb_datapath #(.AddrW(AddrW), .CntW(CntW), .RuntLen(RuntLen)) dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgRingBase(cfgRingBase), .cfgBufSize(cfgBufSize),
    .inData(inData), .inLast(inLast), .inStat(inStat),
    .memRdData(memRdData), .descOwned(descOwned),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr),
    .memWrData(memWrData), .memByteEn(memByteEn)
  );

endmodule

// File: rtl/rx_desc_writeback_chk.sv
module rx_desc_writeback_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       inLast,
  input logic       memWrEn,
  input logic       memRdEn,
  input logic [3:0] memByteEn,
  input logic       irqNoBuf,
  input logic       irqLost
);

  // R11
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));

  // R2
  write_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memByteEn != 4'b0000));

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady);

  // R8
  irq_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqNoBuf |-> irqLost);

  // R8
  irq_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqLost) |-> $past(inValid && inReady && inLast));

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqLost |=> !irqLost);

endmodule

bind rx_desc_writeback rx_desc_writeback_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inLast(inLast), .memWrEn(memWrEn), .memRdEn(memRdEn),
  .memByteEn(memByteEn), .irqNoBuf(irqNoBuf), .irqLost(irqLost)
);

// File: tb/rx_desc_writeback_test.sv
`timescale 1ns/1ps
module rx_desc_writeback_test;

  localparam logic [31:0] RingBase = 32'h100;
  localparam logic [31:0] BufBase0 = 32'h400;
  localparam int RingLen = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic cfgEnable = 1'b0;
  logic [31:0] cfgRingBase = RingBase;
  logic [13:0] cfgBufSize = 14'd1600;
  logic inValid = 1'b0;
  logic inReady;
  logic [7:0] inData = 8'h00;
  logic inLast = 1'b0;
  logic [4:0] inStat = 5'd0;
  logic memWrEn, memRdEn;
  logic [31:0] memAddr, memWrData;
  logic [3:0] memByteEn;
  logic [31:0] memRdData = 32'h0;
  logic irqNoBuf, irqLost;

  rx_desc_writeback uut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgRingBase(cfgRingBase),
    .cfgBufSize(cfgBufSize), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .inStat(inStat),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr),
    .memWrData(memWrData), .memByteEn(memByteEn), .memRdData(memRdData),
    .irqNoBuf(irqNoBuf), .irqLost(irqLost)
  );

  logic [31:0] mem [0:1023];

  always @(posedge clk) begin
    if (memWrEn)
      for (int b = 0; b < 4; b++)
        if (memByteEn[b]) mem[memAddr[11:2]][b*8 +: 8] <= memWrData[b*8 +: 8];
    if (memRdEn) memRdData <= mem[memAddr[11:2]];
  end

  int wrCount = 0, rdCount = 0, clashCount = 0, nbCount = 0, lostCount = 0;
  always @(negedge clk) begin
    if (memWrEn) wrCount++;
    if (memRdEn) rdCount++;
    if (memWrEn && memRdEn) clashCount++;
    if (irqNoBuf) nbCount++;
    if (irqLost) lostCount++;
  end

  int checks = 0, fails = 0;
  int expIdx = 0;
  logic [7:0] fb [0:255];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  function automatic logic [31:0] descA(int idx);
    return RingBase + 32'(idx * 16);
  endfunction

  function automatic logic [31:0] bufA(int idx);
    return BufBase0 + 32'(idx * 256);
  endfunction

  function automatic logic [7:0] memByte(logic [31:0] a);
    return mem[a[11:2]][a[1:0]*8 +: 8];
  endfunction

  function automatic logic [31:0] expWord0(bit eor, int cnt, logic [4:0] st, bit trunc);
    logic [31:0] w;
    w = 32'h3000_0000 | 32'h8000_0000;
    w[30] = eor;
    w[16] = st[0];
    w[17] = st[1];
    w[18] = st[2];
    w[19] = st[3];
    w[22] = st[4];
    w[20] = trunc;
    w[21] = !trunc && (cnt < 64);
    w[13:0] = 14'(cnt);
    return w;
  endfunction

  task automatic releaseDesc(int idx);
    mem[descA(idx) >> 2] <= mem[descA(idx) >> 2] & 32'h7fff_ffff;
    @(negedge clk);
  endtask

  task automatic initRing();
    for (int i = 0; i < RingLen; i++) begin
      mem[descA(i) >> 2] <= (i == RingLen - 1) ? 32'h4000_0000 : 32'h0;
      mem[(descA(i) >> 2) + 3] <= bufA(i);
    end
    @(negedge clk);
  endtask

  task automatic prepBuf(int idx);
    for (int j = 0; j < 64; j++) mem[(bufA(idx) >> 2) + 32'(j)] <= 32'hA5A5A5A5;
    @(negedge clk);
  endtask

  task automatic sendFrame(int len, logic [4:0] st);
    for (int i = 0; i < len; i++) begin
      while (!inReady) @(negedge clk);
      inValid = 1'b1;
      inData = fb[i];
      inLast = (i == len - 1);
      inStat = st;
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast = 1'b0;
    // R10
    chk(!inReady, "R10 ready after last", {31'd0, inReady}, 32'd0);
  endtask

  task automatic doFrame(int len, logic [4:0] st, bit relAfter, string req);
    int cnt;
    bit trunc;
    bit eor;
    bit bytesOk;
    logic [31:0] w0;
    prepBuf(expIdx);
    for (int i = 0; i < 256; i++) fb[i] = 8'($urandom);
    sendFrame(len, st);
    repeat (8) @(negedge clk);
    trunc = len > int'(cfgBufSize);
    cnt = trunc ? int'(cfgBufSize) : len;
    eor = (expIdx == RingLen - 1);
    w0 = mem[descA(expIdx) >> 2];
    chk(w0 == expWord0(eor, cnt, st, trunc), req, w0, expWord0(eor, cnt, st, trunc));
    bytesOk = 1'b1;
    for (int j = 0; j < cnt; j++) if (memByte(bufA(expIdx) + 32'(j)) != fb[j]) bytesOk = 1'b0;
    for (int j = cnt; j < cnt + 4; j++) if (memByte(bufA(expIdx) + 32'(j)) != 8'hA5) bytesOk = 1'b0;
    // R2 R6 payload placement and limit
    chk(bytesOk, "R2/R6 buffer bytes", {31'd0, bytesOk}, 32'd1);
    if (relAfter) releaseDesc(expIdx);
    expIdx = eor ? 0 : expIdx + 1;
  endtask

  initial begin
    int nb0, lost0, wr0, rd0;
    logic [31:0] saved;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!inReady && !memWrEn && !memRdEn, "R9 reset idle", {29'd0, inReady, memWrEn, memRdEn}, 32'd0);
    chk(!irqNoBuf && !irqLost, "R8 reset irq", {30'd0, irqNoBuf, irqLost}, 32'd0);
    rstN = 1'b1;
    initRing();
    cfgEnable = 1'b1;
    @(negedge clk);
    // R1 first read at ring base
    chk(memRdEn && memAddr == RingBase, "R1 word0 fetch", memAddr, RingBase);
    @(negedge clk);
    chk(memRdEn && memAddr == RingBase + 32'd12, "R1 word3 fetch", memAddr, RingBase + 32'd12);

    // R3 R4 R5 R7 random frames with wrap
    for (int f = 0; f < 10; f++)
      doFrame(1 + int'($urandom % 120), 5'($urandom), 1'b1, "R3/R4/R5/R7 word0");

    // R5 R6 limit boundary, limit not a multiple of four
    cfgBufSize = 14'd21;
    doFrame(21, 5'b00000, 1'b1, "R5 exact limit runt");
    doFrame(22, 5'b10101, 1'b1, "R6 one over limit");
    doFrame(30, 5'b01010, 1'b1, "R6 truncated");
    cfgBufSize = 14'd1600;
    doFrame(64, 5'b00000, 1'b1, "R5 at runt boundary");
    doFrame(63, 5'b11111, 1'b1, "R5 below runt boundary");

    // R8 fill ring without release, then drop
    for (int f = 0; f < RingLen; f++) doFrame(8 + f, 5'd0, 1'b0, "R8 fill ring");
    repeat (10) @(negedge clk);
    saved = mem[descA(expIdx) >> 2];
    nb0 = nbCount;
    lost0 = lostCount;
    wr0 = wrCount;
    for (int i = 0; i < 256; i++) fb[i] = 8'($urandom);
    sendFrame(10, 5'd3);
    repeat (3) @(negedge clk);
    chk(nbCount == nb0 + 1, "R8 no-buffer pulse", 32'(nbCount - nb0), 32'd1);
    chk(lostCount == lost0 + 1, "R8 lost pulse", 32'(lostCount - lost0), 32'd1);
    chk(wrCount == wr0, "R8 no memory write", 32'(wrCount - wr0), 32'd0);
    chk(mem[descA(expIdx) >> 2] == saved, "R8 descriptor untouched", mem[descA(expIdx) >> 2], saved);
    releaseDesc(expIdx);
    repeat (10) @(negedge clk);
    doFrame(40, 5'b00100, 1'b1, "R8 poll after release");
    for (int i = 0; i < RingLen; i++) releaseDesc(i);

    // R9 disable then restart at base
    cfgEnable = 1'b0;
    repeat (12) @(negedge clk);
    wr0 = wrCount;
    rd0 = rdCount;
    chk(!inReady, "R9 disabled not ready", {31'd0, inReady}, 32'd0);
    repeat (20) @(negedge clk);
    chk(wrCount == wr0 && rdCount == rd0, "R9 port idle", 32'(wrCount - wr0 + rdCount - rd0), 32'd0);
    cfgEnable = 1'b1;
    expIdx = 0;
    repeat (6) @(negedge clk);
    doFrame(70, 5'b00010, 1'b1, "R9 restart at base");

    // R11
    chk(clashCount == 0, "R11 read/write exclusive", 32'(clashCount), 32'd0);
    summary();
  end

endmodule